// File: doc/BRIEF.md
# Mode-Dependent GPIO Port Controller

This block controls one general-purpose I/O port of `WIDTH` pins (eight by default). Software programs three registers through a simple write/read interface: a pin direction register, a latched output data register and an input pull-up control register. In GPIO use, each pin's output enable follows its direction bit and its output value follows the data register. An input pin receives a pull-up only when its pull-up bit is set.

The chip's operating mode and its external bus width decide who owns the pins. When the mode supports an external memory bus and the wide (16-bit) bus is selected, the external bus takes the port over as the upper data byte. The direction register is then ignored, the pins follow the bus controller's drive enable and write data, and all pull-ups are off. Ownership is held in a two-state machine, `USE_GPIO` and `USE_BUS`. Transition `TAKE_BUS` leads from `USE_GPIO` to `USE_BUS` when a bus-capable mode and the wide bus are both selected. Transition `RELEASE_BUS` leads back as soon as either one goes away. In all other cases each state holds.

Three inputs decide what the pull-up register keeps. Power-on reset and hardware standby clear it. Manual reset and software standby preserve it. The direction and data registers clear on both kinds of reset.

Top module: `gpio_port_ctrl`

## Requirements
- R1: With `op_mode` equal to 3, 7, 0 or any value 8..15, the port is in GPIO use whatever `bus_wide` is: `pin_oe[i]` equals direction bit i (1 = output) and `pin_out` equals the data register.
- R2: With `op_mode` equal to 1, 2, 4, 5 or 6 and `bus_wide` = 0, the port is in GPIO use exactly as in R1.
- R3: With `op_mode` equal to 1, 2, 4, 5 or 6 and `bus_wide` = 1, the port is in bus use: every `pin_oe` bit equals `bus_oe`, `pin_out` equals `bus_wdata`, and the direction register has no effect on the pins. `bus_rdata` always equals `pin_in`.
- R4: In GPIO use, `pin_pu[i]` = pull-up bit i AND NOT direction bit i. In bus use, `pin_pu` is all zero.
- R5: The pin owner follows `op_mode` and `bus_wide` one clock edge after they change. Until that edge, the pins keep the previous owner's behaviour.
- R6: While `rst_n` is low (power-on reset), the direction, data and pull-up registers all read 0, and `pin_oe` and `pin_pu` are 0.
- R7: At every clock edge where `lp_state` = 2'b10 (hardware standby), the pull-up register is cleared. This takes priority over a write to it in the same cycle. The direction and data registers are not changed by the standby itself.
- R8: At an edge where `man_rst` = 1, the direction and data registers are cleared, the pull-up register keeps its value, and any register write in that cycle is discarded.
- R9: `lp_state` = 2'b01 (software standby) and 2'b11 change no register; writes still take effect as in R10.
- R10: Register addresses: 0 = data, 1 = direction, 2 = pull-up. A write with `reg_we` = 1 is visible from the next clock edge. Address 3 reads 0, and writes to it change nothing.
- R11: A read of address 0 returns, per bit, the data register bit for an output pin and `pin_in` for an input pin. Addresses 1 and 2 return their registers.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Power-on reset, asynchronous, active low |
| man_rst | input | 1 | Manual reset, synchronous, active high |
| lp_state | input | 2 | Low-power state: 00 run, 01 software standby, 10 hardware standby, 11 treated as run |
| op_mode | input | 4 | Chip operating mode |
| bus_wide | input | 1 | 1 selects the 16-bit external bus, 0 the 8-bit bus |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | WIDTH | Register write data |
| reg_rdata | output | WIDTH | Register read data (combinational) |
| pin_in | input | WIDTH | Pad input levels |
| pin_oe | output | WIDTH | Pad output enables |
| pin_out | output | WIDTH | Pad output values |
| pin_pu | output | WIDTH | Pad pull-up enables |
| bus_oe | input | 1 | Bus controller drives the data byte |
| bus_wdata | input | WIDTH | Bus controller write data |
| bus_rdata | output | WIDTH | Pad levels returned to the bus controller |

## Verification
Register writes, reset effects and changes of pin owner all take effect at the first clock edge after the stimulus. Pin outputs derive combinationally from registered state, and `reg_rdata` and `bus_rdata` follow `pin_in`, `reg_addr` and the bus inputs with no delay. The bench therefore changes inputs at the falling edge. Its reference model steps at the rising edge, and it compares one nanosecond after that edge, when both the new state and the unchanged inputs are settled. For R5, an extra check taken before the edge confirms that the old owner still holds the pins.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

    localparam int MODE_W     = 4;
    localparam int REG_ADDR_W = 2;
    localparam int LP_W       = 2;

    localparam logic [REG_ADDR_W-1:0] ADDR_DATA = 2'd0;
    localparam logic [REG_ADDR_W-1:0] ADDR_DIR  = 2'd1;
    localparam logic [REG_ADDR_W-1:0] ADDR_PULL = 2'd2;

    localparam logic [LP_W-1:0] LP_HW_STBY = 2'b10;

    typedef enum logic {
        USE_GPIO = 1'b0,
        USE_BUS  = 1'b1
    } port_use_e;

    // Modes in which the external bus may claim the port as its upper data byte
    function automatic logic mode_bus_capable(input logic [MODE_W-1:0] m);
        case (m)
            4'd1, 4'd2, 4'd4, 4'd5, 4'd6: mode_bus_capable = 1'b1;
            default:                      mode_bus_capable = 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/gpio_port_use_fsm.sv
module gpio_port_use_fsm
    import gpio_port_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] op_mode,
    input  logic              bus_wide,
    output logic              bus_owned
);

    port_use_e state_q, state_d;
    logic      want_bus;

    assign want_bus = mode_bus_capable(op_mode) && bus_wide;

    // Next state: TAKE_BUS / RELEASE_BUS
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            USE_GPIO: if (want_bus)  state_d = USE_BUS;
            USE_BUS:  if (!want_bus) state_d = USE_GPIO;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= USE_GPIO;
        else        state_q <= state_d;
    end

    always_comb begin
        bus_owned = (state_q == USE_BUS);
    end

endmodule

// File: rtl/gpio_port_regs.sv
module gpio_port_regs
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  man_rst,
    input  logic                  hw_stby,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [WIDTH-1:0]      reg_wdata,
    input  logic [WIDTH-1:0]      pin_in,
    output logic [WIDTH-1:0]      reg_rdata,
    output logic [WIDTH-1:0]      dir_q,
    output logic [WIDTH-1:0]      dat_q,
    output logic [WIDTH-1:0]      pull_q
);

    // Direction and data: cleared by either reset
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir_q <= '0;
            dat_q <= '0;
        end else if (man_rst) begin
            dir_q <= '0;
            dat_q <= '0;
        end else if (reg_we) begin
            if (reg_addr == ADDR_DIR)  dir_q <= reg_wdata;
            if (reg_addr == ADDR_DATA) dat_q <= reg_wdata;
        end
    end

    // Pull-up control: cleared by power-on reset and hardware standby only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pull_q <= '0;
        end else if (hw_stby) begin
            pull_q <= '0;
        end else if (reg_we && !man_rst && reg_addr == ADDR_PULL) begin
            pull_q <= reg_wdata;
        end
    end

    always_comb begin
        case (reg_addr)
            ADDR_DATA: reg_rdata = (dir_q & dat_q) | (~dir_q & pin_in);
            ADDR_DIR:  reg_rdata = dir_q;
            ADDR_PULL: reg_rdata = pull_q;
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/gpio_port_pin_mux.sv
module gpio_port_pin_mux #(
    parameter int WIDTH = 8
) (
    input  logic             bus_owned,
    input  logic [WIDTH-1:0] dir_q,
    input  logic [WIDTH-1:0] dat_q,
    input  logic [WIDTH-1:0] pull_q,
    input  logic             bus_oe,
    input  logic [WIDTH-1:0] bus_wdata,
    output logic [WIDTH-1:0] pin_oe,
    output logic [WIDTH-1:0] pin_out,
    output logic [WIDTH-1:0] pin_pu
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        assign pin_oe[i]  = bus_owned ? bus_oe       : dir_q[i];
        assign pin_out[i] = bus_owned ? bus_wdata[i] : dat_q[i];
        assign pin_pu[i]  = !bus_owned && pull_q[i] && !dir_q[i];
    end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  man_rst,
    input  logic [LP_W-1:0]       lp_state,
    input  logic [MODE_W-1:0]     op_mode,
    input  logic                  bus_wide,
    input  logic                  reg_we,
    input  logic [REG_ADDR_W-1:0] reg_addr,
    input  logic [WIDTH-1:0]      reg_wdata,
    output logic [WIDTH-1:0]      reg_rdata,
    input  logic [WIDTH-1:0]      pin_in,
    output logic [WIDTH-1:0]      pin_oe,
    output logic [WIDTH-1:0]      pin_out,
    output logic [WIDTH-1:0]      pin_pu,
    input  logic                  bus_oe,
    input  logic [WIDTH-1:0]      bus_wdata,
    output logic [WIDTH-1:0]      bus_rdata
);

    logic             bus_owned;
    logic             hw_stby;
    logic [WIDTH-1:0] dir_q, dat_q, pull_q;

    assign hw_stby   = (lp_state == LP_HW_STBY);
    assign bus_rdata = pin_in;

    gpio_port_use_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .op_mode   (op_mode),
        .bus_wide  (bus_wide),
        .bus_owned (bus_owned)
    );

    gpio_port_regs #(.WIDTH(WIDTH)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .man_rst   (man_rst),
        .hw_stby   (hw_stby),
        .reg_we    (reg_we),
        .reg_addr  (reg_addr),
        .reg_wdata (reg_wdata),
        .pin_in    (pin_in),
        .reg_rdata (reg_rdata),
        .dir_q     (dir_q),
        .dat_q     (dat_q),
        .pull_q    (pull_q)
    );

    gpio_port_pin_mux #(.WIDTH(WIDTH)) u_mux (
        .bus_owned (bus_owned),
        .dir_q     (dir_q),
        .dat_q     (dat_q),
        .pull_q    (pull_q),
        .bus_oe    (bus_oe),
        .bus_wdata (bus_wdata),
        .pin_oe    (pin_oe),
        .pin_out   (pin_out),
        .pin_pu    (pin_pu)
    );

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
    import gpio_port_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              man_rst,
    input logic [LP_W-1:0]   lp_state,
    input logic [MODE_W-1:0] op_mode,
    input logic              bus_wide,
    input logic [WIDTH-1:0]  pin_oe,
    input logic [WIDTH-1:0]  pin_out,
    input logic [WIDTH-1:0]  pin_pu,
    input logic              bus_oe,
    input logic [WIDTH-1:0]  bus_wdata
);

    logic bus_sel;
    assign bus_sel = mode_bus_capable(op_mode) && bus_wide;

    assert_bus_drives_pins_R3: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> (pin_oe == {WIDTH{bus_oe}} && pin_out == bus_wdata));

    assert_bus_no_pullup_R4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_sel |=> (pin_pu == '0));

    assert_pullup_inputs_only_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (pin_pu & pin_oe) == '0);

    assert_hw_stby_clears_pull_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (lp_state == LP_HW_STBY) |=> (pin_pu == '0));

    assert_man_rst_inputs_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (man_rst && !bus_sel) |=> (pin_oe == '0));

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.WIDTH(WIDTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .man_rst   (man_rst),
    .lp_state  (lp_state),
    .op_mode   (op_mode),
    .bus_wide  (bus_wide),
    .pin_oe    (pin_oe),
    .pin_out   (pin_out),
    .pin_pu    (pin_pu),
    .bus_oe    (bus_oe),
    .bus_wdata (bus_wdata)
);

// File: tb/sim_gpio_port_ctrl.sv
`timescale 1ns/1ps
module sim_gpio_port_ctrl;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         man_rst = 1'b0;
    logic [1:0]   lp_state = 2'b00;
    logic [3:0]   op_mode = 4'd7;
    logic         bus_wide = 1'b0;
    logic         reg_we = 1'b0;
    logic [1:0]   reg_addr = 2'd0;
    logic [W-1:0] reg_wdata = '0;
    logic [W-1:0] reg_rdata;
    logic [W-1:0] pin_in = '0;
    logic [W-1:0] pin_oe, pin_out, pin_pu;
    logic         bus_oe = 1'b0;
    logic [W-1:0] bus_wdata = '0;
    logic [W-1:0] bus_rdata;

    int n_chk = 0;
    int n_bad = 0;
    int cyc = 0;

    // model state
    logic [W-1:0] m_dir = '0, m_dat = '0, m_pull = '0;
    logic         m_bus = 1'b0;

    always #4 clk = ~clk;

    gpio_port_ctrl #(.WIDTH(W)) u0 (
        .clk(clk), .rst_n(rst_n), .man_rst(man_rst), .lp_state(lp_state),
        .op_mode(op_mode), .bus_wide(bus_wide), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .pin_in(pin_in), .pin_oe(pin_oe), .pin_out(pin_out), .pin_pu(pin_pu),
        .bus_oe(bus_oe), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata)
    );

    function automatic logic capable(input logic [3:0] m);
        return (m == 4'd1 || m == 4'd2 || m == 4'd4 || m == 4'd5 || m == 4'd6);
    endfunction

    function automatic logic [W-1:0] exp_oe();
        return m_bus ? {W{bus_oe}} : m_dir;
    endfunction
    function automatic logic [W-1:0] exp_out();
        return m_bus ? bus_wdata : m_dat;
    endfunction
    function automatic logic [W-1:0] exp_pu();
        return m_bus ? '0 : (m_pull & ~m_dir);
    endfunction
    function automatic logic [W-1:0] exp_rd();
        case (reg_addr)
            2'd0:    return (m_dir & m_dat) | (~m_dir & pin_in);
            2'd1:    return m_dir;
            2'd2:    return m_pull;
            default: return '0;
        endcase
    endfunction

    task automatic chk(input string tag, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", tag, what, act, exp, cyc);
        end
    endtask

    task automatic check_all(input string tag);
        chk(m_bus ? "R3" : "R1", "pin_oe", pin_oe, exp_oe());
        chk(m_bus ? "R3" : "R1", "pin_out", pin_out, exp_out());
        chk("R4", "pin_pu", pin_pu, exp_pu());
        chk("R11", "reg_rdata", reg_rdata, exp_rd());
        chk("R3", "bus_rdata", bus_rdata, pin_in);
        if (tag != "") chk(tag, "reg_rdata", reg_rdata, exp_rd());
    endtask

    // Advance one clock: model steps with the inputs present at the edge
    task automatic tick(input string tag);
        logic [W-1:0] nd, nt, np;
        logic nb;
        nd = m_dir; nt = m_dat; np = m_pull;
        nb = capable(op_mode) && bus_wide;
        if (man_rst) begin
            nd = '0; nt = '0;
        end else if (reg_we) begin
            if (reg_addr == 2'd0) nt = reg_wdata;
            if (reg_addr == 2'd1) nd = reg_wdata;
            if (reg_addr == 2'd2) np = reg_wdata;
        end
        if (lp_state == 2'b10) np = '0;
        @(posedge clk);
        m_dir = nd; m_dat = nt; m_pull = np; m_bus = nb;
        #1;
        check_all(tag);
        @(negedge clk);
    endtask

    task automatic wr(input logic [1:0] a, input logic [W-1:0] d, input string tag);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        tick(tag);
        reg_we = 1'b0;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [W-1:0] exp, input string tag);
        reg_addr = a;
        #1;
        chk(tag, "readback", reg_rdata, exp);
    endtask

    initial begin
        while (cyc < 100000) begin
            @(posedge clk);
            cyc++;
        end
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        // R6: power-on reset state
        repeat (3) @(negedge clk);
        reg_addr = 2'd1; #1;
        chk("R6", "dir during reset", reg_rdata, '0);
        chk("R6", "pin_oe during reset", pin_oe, '0);
        chk("R6", "pin_pu during reset", pin_pu, '0);
        rst_n = 1'b1;
        tick("R6");

        // R1/R4/R10: mode 3 GPIO, pull-ups only on inputs
        op_mode = 4'd3; bus_wide = 1'b1;
        wr(2'd2, 8'hFF, "R10");
        wr(2'd1, 8'h0F, "R10");
        wr(2'd0, 8'h3C, "R10");
        chk("R4", "pin_pu mode3", pin_pu, 8'hF0);
        chk("R1", "pin_oe mode3", pin_oe, 8'h0F);
        // R11: mixed readback
        pin_in = 8'h55;
        rd_chk(2'd0, 8'h3C & 8'h0F | 8'h50, "R11");
        // R10: address 3 reads 0 and write ignored
        wr(2'd3, 8'hA5, "R10");
        rd_chk(2'd3, 8'h00, "R10");
        rd_chk(2'd1, 8'h0F, "R10");
        // R1: invalid modes 0 and 9 behave as plain I/O
        op_mode = 4'd0; tick("R1");
        chk("R1", "pin_oe mode0", pin_oe, 8'h0F);
        op_mode = 4'd9; tick("R1");
        chk("R1", "pin_out mode9", pin_out, 8'h3C);
        // R2: mode 2 with narrow bus
        op_mode = 4'd2; bus_wide = 1'b0; tick("R2");
        chk("R2", "pin_oe mode2 narrow", pin_oe, 8'h0F);
        // R5: wide bus takes effect one edge later
        bus_wide = 1'b1; bus_oe = 1'b1; bus_wdata = 8'h96;
        #1;
        chk("R5", "pin_oe before edge", pin_oe, 8'h0F);
        tick("R5");
        chk("R3", "pin_oe bus", pin_oe, 8'hFF);
        chk("R3", "pin_out bus", pin_out, 8'h96);
        chk("R4", "pin_pu bus", pin_pu, 8'h00);
        bus_oe = 1'b0; tick("R3");
        chk("R3", "pin_oe bus idle", pin_oe, 8'h00);
        bus_wide = 1'b0; tick("R5");
        chk("R5", "pin_oe released", pin_oe, 8'h0F);

        // R9: software standby changes nothing
        lp_state = 2'b01;
        repeat (5) tick("R9");
        rd_chk(2'd2, 8'hFF, "R9");
        lp_state = 2'b00;

        // R7: hardware standby beats a pull-up write, leaves dir/data alone
        lp_state = 2'b10;
        wr(2'd2, 8'hAA, "R7");
        lp_state = 2'b00;
        rd_chk(2'd2, 8'h00, "R7");
        rd_chk(2'd1, 8'h0F, "R7");

        // R8: manual reset keeps pull-ups, clears dir/data, drops writes
        wr(2'd2, 8'hC3, "R8");
        man_rst = 1'b1;
        wr(2'd1, 8'hFF, "R8");
        man_rst = 1'b0;
        rd_chk(2'd1, 8'h00, "R8");
        rd_chk(2'd2, 8'hC3, "R8");
        chk("R8", "pin_pu after manual reset", pin_pu, 8'hC3);

        // Random phase
        for (int k = 0; k < 3000; k++) begin
            op_mode   = 4'($urandom_range(0, 15));
            bus_wide  = 1'($urandom);
            man_rst   = ($urandom_range(0, 31) == 0);
            lp_state  = ($urandom_range(0, 15) == 0) ? 2'b10 : 2'($urandom_range(0, 1) * $urandom_range(0, 3) & 2'b01);
            reg_we    = 1'($urandom);
            reg_addr  = 2'($urandom);
            reg_wdata = W'($urandom);
            pin_in    = W'($urandom);
            bus_oe    = 1'($urandom);
            bus_wdata = W'($urandom);
            tick("");
        end

        // R6: power-on reset again clears pull-ups
        reg_we = 1'b0; man_rst = 1'b0; lp_state = 2'b00;
        wr(2'd2, 8'h7E, "R10");
        rst_n = 1'b0; #1;
        rd_chk(2'd2, 8'h00, "R6");
        m_dir = '0; m_dat = '0; m_pull = '0; m_bus = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        tick("R6");

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule